// File: doc/BRIEF.md
# Slave-Mode Stereo Serial Audio Transceiver

This block connects a processing core to a two-channel serial audio link running in I2S format. The bit clock and the LR (word-select) clock come from outside, and the block only observes them. It runs on its own system clock. Both link clocks and the serial input pass through a short synchroniser, and the block then works from the detected bit-clock edges. The bit-clock half period must last at least `SYNC_STAGES + 2` system-clock cycles.

Each channel slot is 32 bit-clock periods long. LR low marks the left slot and LR high marks the right slot. A 24-bit sample travels MSB first, and its MSB sits in the second bit period after the LR change.

On the receive side, the serial input is collected into 24-bit words. Each completed word is handed over with a one-cycle strobe when LR changes level. On the transmit side, the block captures the parallel word for the new slot when LR changes, and it shifts that word out in the same format. Because the output format matches the input format, several units can be chained, each feeding the next.

Top module: `i2s_slave_xcvr`

## Requirements
- R1: While reset is asserted and just after it is released, `sd_o` is low, both strobes are low, and both received words are zero.
- R2: The receiver samples `sd_i` on bit-clock rising edges. Slot position 0 is the first rising edge on which a new LR level is seen. The 24 bits at positions 1 to 24 form the word, MSB at position 1. LR low (0) gives a left word and LR high (1) gives a right word.
- R3: Serial input bits at slot positions 0 and 25 to 31 have no effect on the received word.
- R4: Every LR transition after the first produces exactly one single-cycle strobe. The strobe belongs to the channel of the slot that just ended, and it comes with that slot's word. Each received word stays stable until that channel's next strobe, and the two strobes are never high together.
- R5: The first LR transition after reset produces no strobe, because the slot before it is incomplete. `sd_o` stays low until that first transition.
- R6: On the rising edge where a transition is seen, the transmitter captures `tx_right_i` if LR went high, or `tx_left_i` if LR went low. It drives that word MSB first on `sd_o` at slot positions 1 to 24.
- R7: `sd_o` is low at slot positions 0 and 25 to 31.
- R8: `sd_o` changes only in response to a bit-clock falling edge.
- R9: Changing `tx_left_i` or `tx_right_i` while a slot is being sent does not alter the bits of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_i | input | 1 | External bit clock |
| lr_i | input | 1 | External LR clock, low = left, high = right |
| sd_i | input | 1 | Serial audio data in |
| sd_o | output | 1 | Serial audio data out, same format as the input |
| tx_left_i | input | 24 | Left word to transmit |
| tx_right_i | input | 24 | Right word to transmit |
| rx_left_o | output | 24 | Last received left word |
| rx_right_o | output | 24 | Last received right word |
| rx_left_vld_o | output | 1 | One-cycle strobe marking a new left word |
| rx_right_vld_o | output | 1 | One-cycle strobe marking a new right word |

## Verification
The hardest case to reach from the ports is the stretch before the first complete slot. Here the receiver must stay silent and the transmitter must stay low, even though bit-clock edges are already arriving. The stimulus reaches it by releasing reset into a truncated left slot that holds real data bits, so any premature strobe or early output would be visible.

The second hard case is a parallel word that changes while its own slot is on the wire. The stimulus rewrites that channel's transmit input with random data at slot position 5, in every slot of the sweep.

The sweep then runs walking-one, all-zero, all-one, single-end and random words on both channels, with random bits placed outside the data positions.

// File: rtl/i2s_xcvr_pkg.sv
package i2s_xcvr_pkg;
    // Channel selected by the LR clock level
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/i2s_edge_sync.sv
module i2s_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic lr_i,
    input  logic sd_i,
    output logic bck_rise,
    output logic bck_fall,
    output logic lr_s,
    output logic sd_s
);
    typedef struct packed {
        logic [STAGES-1:0] bck;
        logic [STAGES-1:0] lr;
        logic [STAGES-1:0] sd;
        logic              bck_last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.bck      = {st_q.bck[STAGES-2:0], bck_i};
        st_d.lr       = {st_q.lr[STAGES-2:0], lr_i};
        st_d.sd       = {st_q.sd[STAGES-2:0], sd_i};
        st_d.bck_last = st_q.bck[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Edges are detected from the last two stages, so the edge pulses
    // line up with the lr_s and sd_s values taken from the same stage.
    assign bck_rise = st_q.bck[STAGES-1] & ~st_q.bck_last;
    assign bck_fall = ~st_q.bck[STAGES-1] & st_q.bck_last;
    assign lr_s     = st_q.lr[STAGES-1];
    assign sd_s     = st_q.sd[STAGES-1];
endmodule

// File: rtl/i2s_slot_track.sv
module i2s_slot_track
    import i2s_xcvr_pkg::*;
#(
    parameter int SLOT_W = 32,
    localparam int POS_W = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bck_rise,
    input  logic             lr_s,
    output logic             slot_start,
    output logic             slot_strobe,
    output chan_e            ended_chan,
    output logic [POS_W-1:0] bit_pos,
    output logic             armed
);
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(SLOT_W - 1);

    typedef struct packed {
        logic             lr;
        logic             seen;
        logic             armed;
        logic [POS_W-1:0] pos;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        // A transition needs a previously seen LR level to compare against
        slot_start  = bck_rise & st_q.seen & (lr_s != st_q.lr);
        slot_strobe = slot_start & st_q.armed;
        ended_chan  = chan_e'(st_q.lr);
        if (slot_start) begin
            bit_pos = '0;
        end else if (st_q.pos == POS_MAX) begin
            bit_pos = st_q.pos;
        end else begin
            bit_pos = st_q.pos + POS_W'(1);
        end
        if (bck_rise) begin
            st_d.lr   = lr_s;
            st_d.seen = 1'b1;
            st_d.pos  = bit_pos;
            if (slot_start) begin
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_xcvr_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32,
    localparam int POS_W = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_rise,
    input  logic              sd_s,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              slot_strobe,
    input  chan_e             ended_chan,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              left_vld_o,
    output logic              right_vld_o
);
    localparam logic [POS_W-1:0] LAST_BIT = POS_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
        logic              lv;
        logic              rv;
    } rx_t;

    rx_t  st_d, st_q;
    logic data_bit;

    always_comb begin
        st_d     = st_q;
        st_d.lv  = 1'b0;
        st_d.rv  = 1'b0;
        data_bit = bck_rise && (bit_pos != '0) && (bit_pos <= LAST_BIT);
        if (data_bit) begin
            st_d.sh = {st_q.sh[WORD_W-2:0], sd_s};
        end
        if (slot_strobe) begin
            if (ended_chan == CH_RIGHT) begin
                st_d.right = st_q.sh;
                st_d.rv    = 1'b1;
            end else begin
                st_d.left  = st_q.sh;
                st_d.lv    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign left_o      = st_q.left;
    assign right_o     = st_q.right;
    assign left_vld_o  = st_q.lv;
    assign right_vld_o = st_q.rv;
endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
    import i2s_xcvr_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_start,
    input  logic              lr_s,
    input  logic              bck_fall,
    input  logic [WORD_W-1:0] tx_left_i,
    input  logic [WORD_W-1:0] tx_right_i,
    output logic              sd_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic              out;
    } tx_t;

    tx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Loading on the position-0 rising edge puts the MSB out on the
        // following falling edge; zeros shifted in fill the slot tail.
        if (slot_start) begin
            st_d.sh = (chan_e'(lr_s) == CH_RIGHT) ? tx_right_i : tx_left_i;
        end else if (bck_fall) begin
            st_d.out = st_q.sh[WORD_W-1];
            st_d.sh  = {st_q.sh[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sd_o = st_q.out;
endmodule

// File: rtl/i2s_slave_xcvr.sv
module i2s_slave_xcvr
    import i2s_xcvr_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int POS_W      = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_i,
    input  logic              lr_i,
    input  logic              sd_i,
    output logic              sd_o,
    input  logic [WORD_W-1:0] tx_left_i,
    input  logic [WORD_W-1:0] tx_right_i,
    output logic [WORD_W-1:0] rx_left_o,
    output logic [WORD_W-1:0] rx_right_o,
    output logic              rx_left_vld_o,
    output logic              rx_right_vld_o
);
    logic             bck_rise;
    logic             bck_fall;
    logic             lr_s;
    logic             sd_s;
    logic             slot_start;
    logic             slot_strobe;
    chan_e            ended_chan;
    logic [POS_W-1:0] bit_pos;
    logic             slot_armed;

    i2s_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_i    (bck_i),
        .lr_i     (lr_i),
        .sd_i     (sd_i),
        .bck_rise (bck_rise),
        .bck_fall (bck_fall),
        .lr_s     (lr_s),
        .sd_s     (sd_s)
    );

    i2s_slot_track #(.SLOT_W(SLOT_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .bck_rise    (bck_rise),
        .lr_s        (lr_s),
        .slot_start  (slot_start),
        .slot_strobe (slot_strobe),
        .ended_chan  (ended_chan),
        .bit_pos     (bit_pos),
        .armed       (slot_armed)
    );

    i2s_rx_deser #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bck_rise    (bck_rise),
        .sd_s        (sd_s),
        .bit_pos     (bit_pos),
        .slot_strobe (slot_strobe),
        .ended_chan  (ended_chan),
        .left_o      (rx_left_o),
        .right_o     (rx_right_o),
        .left_vld_o  (rx_left_vld_o),
        .right_vld_o (rx_right_vld_o)
    );

    i2s_tx_ser #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .lr_s       (lr_s),
        .bck_fall   (bck_fall),
        .tx_left_i  (tx_left_i),
        .tx_right_i (tx_right_i),
        .sd_o       (sd_o)
    );
endmodule

// File: rtl/i2s_xcvr_chk.sv
module i2s_xcvr_chk #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_o,
    input logic              lvld,
    input logic              rvld,
    input logic [WORD_W-1:0] rxl,
    input logic [WORD_W-1:0] rxr,
    input logic              bck_fall,
    input logic              armed
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lvld && rvld)); // R4

    AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lvld |=> !lvld); // R4

    AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rvld |=> !rvld); // R4

    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(rxl) |-> lvld); // R4

    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(rxr) |-> rvld); // R4

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sd_o) |-> $past(bck_fall)); // R8

    AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!sd_o && !lvld && !rvld)); // R5
endmodule

bind i2s_slave_xcvr i2s_xcvr_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_o     (sd_o),
    .lvld     (rx_left_vld_o),
    .rvld     (rx_right_vld_o),
    .rxl      (rx_left_o),
    .rxr      (rx_right_o),
    .bck_fall (bck_fall),
    .armed    (slot_armed)
);

// File: tb/sim_i2s_slave_xcvr.sv
module sim_i2s_slave_xcvr;
    localparam int W    = 24;
    localparam int HALF = 6;   // system clocks per bit-clock half period

    logic clk = 1'b0;
    always #2 clk = ~clk;      // 250 MHz

    logic         rst_n, bck_i, lr_i, sd_i, sd_o;
    logic [W-1:0] tx_left_i, tx_right_i, rx_left_o, rx_right_o;
    logic         rx_left_vld_o, rx_right_vld_o;

    i2s_slave_xcvr u0 (
        .clk(clk), .rst_n(rst_n), .bck_i(bck_i), .lr_i(lr_i), .sd_i(sd_i),
        .sd_o(sd_o), .tx_left_i(tx_left_i), .tx_right_i(tx_right_i),
        .rx_left_o(rx_left_o), .rx_right_o(rx_right_o),
        .rx_left_vld_o(rx_left_vld_o), .rx_right_vld_o(rx_right_vld_o)
    );

    int           nchk = 0;
    int           nerr = 0;
    bit           done = 0;
    logic         lr_cur;
    bit           tx_on;
    logic [W-1:0] cur_txw, expl, expr;
    bit           penl, penr;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int k);
        if (k < W)       return W'(1) << k;
        else if (k == W)     return '0;
        else if (k == W + 1) return '1;
        else if (k == W + 2) return {1'b1, {(W-1){1'b0}}};
        else if (k == W + 3) return W'(1);
        else if (k == W + 4) return {(W/2){2'b10}};
        else                 return W'($urandom);
    endfunction

    function automatic logic [W-1:0] tx_l(input int k);
        logic [W-1:0] p = pat(k);
        return {p[0], p[W-1:1]} ^ 24'h0F0F0F;
    endfunction

    function automatic logic [W-1:0] tx_r(input int k);
        return pat(k) ^ 24'hC3C3C3;
    endfunction

    // Strobe monitor: R2, R3, R4, R5
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_left_vld_o) begin
                chk(penl && rx_left_o == expl, "R4", "left strobe/word (R2 R3 R5)", rx_left_o, expl);
                penl = 0;
            end
            if (rx_right_vld_o) begin
                chk(penr && rx_right_o == expr, "R4", "right strobe/word (R2 R3 R5)", rx_right_o, expr);
                penr = 0;
            end
        end
    end

    // One slot of npos bit periods on channel ch carrying word w
    task automatic do_slot(input logic ch, input logic [W-1:0] w,
                           input logic [W-1:0] nxt_other, input int npos, input bit full);
        bit start = 0;
        for (int p = 0; p < npos; p++) begin
            bck_i = 1'b0;
            lr_i  = ch;
            if (p == 0 && ch != lr_cur) start = 1;
            sd_i = (p >= 1 && p <= W) ? w[W-p] : 1'($urandom_range(0, 1));
            if (p == 5) begin   // R9: rewrite own channel mid-slot
                if (ch) tx_right_i = W'($urandom);
                else    tx_left_i  = W'($urandom);
            end
            if (p == 9) begin
                if (ch) tx_left_i  = nxt_other;
                else    tx_right_i = nxt_other;
            end
            repeat (HALF) @(negedge clk);
            begin
                logic e;
                e = (tx_on && p >= 1 && p <= W) ? cur_txw[W-p] : 1'b0;
                // R6 data bits, R7 tail bits, R5 low before arming, R9
                chk(sd_o == e, (p >= 1 && p <= W && tx_on) ? "R6" : "R7",
                    $sformatf("sd_o pos %0d (R5 R9)", p), {{(W-1){1'b0}}, sd_o}, {{(W-1){1'b0}}, e});
            end
            bck_i = 1'b1;
            if (start && p == 0) begin
                tx_on   = 1;
                cur_txw = ch ? tx_right_i : tx_left_i;
                lr_cur  = ch;
            end
            repeat (HALF) @(negedge clk);
        end
        if (full) begin
            if (ch) begin expr = w; penr = 1; end
            else    begin expl = w; penl = 1; end
        end
    endtask

    initial begin
        rst_n = 1'b0; bck_i = 1'b1; lr_i = 1'b0; sd_i = 1'b0;
        tx_left_i = '0; tx_right_i = '0;
        lr_cur = 1'b0; tx_on = 0; cur_txw = '0;
        expl = '0; expr = '0; penl = 0; penr = 0;
        repeat (5) @(negedge clk);
        chk(sd_o == 1'b0, "R1", "sd_o in reset", {23'b0, sd_o}, '0);
        chk(!rx_left_vld_o && !rx_right_vld_o, "R1", "strobes in reset",
            {22'b0, rx_left_vld_o, rx_right_vld_o}, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_left_o == '0, "R1", "left word after reset", rx_left_o, '0);
        chk(rx_right_o == '0, "R1", "right word after reset", rx_right_o, '0);
        chk(sd_o == 1'b0, "R1", "sd_o after reset", {23'b0, sd_o}, '0);

        // R5: truncated left slot before the first transition
        do_slot(1'b0, 24'h123456, tx_r(0), 20, 0);

        for (int k = 0; k < W + 10; k++) begin
            do_slot(1'b1, ~pat(k), tx_l(k), 32, 1);
            do_slot(1'b0, pat(k), tx_r(k + 1), 32, 1);
        end
        // closing transition hands over the last left word
        do_slot(1'b1, '0, '0, 4, 0);
        repeat (10) @(negedge clk);
        chk(!penl && !penr, "R4", "missing final strobe", {22'b0, penl, penr}, '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule